// File: doc/BRIEF.md
# ROM Test Column Partition Selector

During a built-in self-test of an embedded read-only memory, this block decides which bit lines of each word being read are passed to the signature compactor. The test controller sweeps the word (column) address and supplies a partition number and a group number. The block then produces a bit mask that covers the columns belonging to that partition within that group. Across a full set of partitions, every column is observed exactly once per word slot. Across different groups, the same column falls into different partitions. Diagnosis software can then locate failing columns by comparing signatures.

A small Galois LFSR, the diffractor, is seeded from the group number when a run starts. It moves one step each time the word address changes. Several lanes read the diffractor through phase shifters. Each phase shifter is a fixed advance along the LFSR's own trajectory, and the offsets are evenly spaced. Each lane XORs its value with the partition number, and the result drives a one-of-B decoder. Lane 0 is forced to zero at word address 0, so the zero combination that the LFSR never reaches still occurs. In trellis runs the seed is the group number plus one, which breaks the pairing with the row selector. Asserting the disable input opens every column.

Top module: `rom_col_selector`

## Requirements
- R1: While `colDisable` is 1, `colMask` is all ones, whatever the other inputs are.
- R2: In a cycle with `runStart` = 1 and `trellisMode` = 0, the diffractor value used in that cycle is `groupNum`, and the block keeps that value for the following cycle.
- R3: In a cycle with `runStart` = 1 and `trellisMode` = 1, the diffractor value is `groupNum + 1`, taken modulo 2^DIFF_W.
- R4: A seed that works out to zero is replaced by 1, so the diffractor is never zero.
- R5: Outside a run start, the diffractor takes one Galois step in any cycle where `wordAddr` differs from its value in the previous cycle, and otherwise holds. A Galois step is next = {s[W-2:0],0} XOR (s[W-1] ? TAPS : 0), with TAPS = 3'b011 by default (x^3+x+1).
- R6: Lane j uses the diffractor value advanced by j*SPACING steps, where SPACING = floor((2^DIFF_W-1)/NUM_LANES).
- R7: When `wordAddr` is 0, the value of lane 0 is forced to 0, so lane 0 selects column `partitionNum`.
- R8: With `colDisable` = 0, bit (partitionNum XOR laneValue_j) of `colMask` is set for each lane j, and no other bit is set. At least 1 and at most NUM_LANES bits are therefore set.
- R9: After reset the diffractor holds 1 and the stored previous address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runStart | input | 1 | Start of a test run; loads the diffractor seed |
| trellisMode | input | 1 | Selects the group+1 seed for combined row/column runs |
| colDisable | input | 1 | Opens all columns when 1 |
| groupNum | input | DIFF_W | Current partition group |
| partitionNum | input | DIFF_W | Current partition inside the group |
| wordAddr | input | ADDR_W | BIST word (column) address |
| colMask | output | 2^DIFF_W | Columns observed for the current word |

## Verification
Directed cases run a known seed through the first two word slots. They compare the mask with values worked out by hand from the default polynomial, which separates a wrong lane offset from a wrong XOR with the partition number. Held addresses and address jumps show whether the diffractor moves on any address change or only on increments. Groups 0 and 2^DIFF_W-1 in trellis runs exercise the zero-seed replacement. A seeded random sweep mixes increments, holds, jumps, run starts, trellis runs and disable, and compares every cycle with a bench model of the diffractor.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  // strobes from the address watcher to the selection datapath
  typedef struct packed {
    logic load;       // seed the diffractor this cycle
    logic step;       // advance the diffractor this cycle
    logic firstBeat;  // word address is zero: gate lane 0
  } rcsCtl_t;
endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runStart,
  input  logic [ADDR_W-1:0] wordAddr,
  output rcsCtl_t           ctl
);
  logic [ADDR_W-1:0] prevAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevAddr <= '0;
    else       prevAddr <= wordAddr;
  end

  always_comb begin
    ctl.load      = runStart;
    ctl.step      = !runStart && (wordAddr != prevAddr);
    ctl.firstBeat = (wordAddr == '0);
  end

  // a load and a step never coincide
  p_load_excl_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load && ctl.step));
endmodule

// File: rtl/rcs_datapath.sv
module rcs_datapath
  import rcs_pkg::*;
#(
  parameter int             DIFF_W    = 3,
  parameter logic [DIFF_W-1:0] TAPS   = 3'b011,
  parameter int             NUM_LANES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rcsCtl_t                 ctl,
  input  logic                    trellisMode,
  input  logic                    colDisable,
  input  logic [DIFF_W-1:0]       groupNum,
  input  logic [DIFF_W-1:0]       partitionNum,
  output logic [(1<<DIFF_W)-1:0]  colMask
);
  localparam int WORD_W  = 1 << DIFF_W;
  localparam int PERIOD  = WORD_W - 1;
  localparam int SPACING = PERIOD / NUM_LANES;

  function automatic logic [DIFF_W-1:0] galoisStep(input logic [DIFF_W-1:0] s);
    galoisStep = {s[DIFF_W-2:0], 1'b0} ^ (s[DIFF_W-1] ? TAPS : '0);
  endfunction

  logic [DIFF_W-1:0] diffState;
  logic [DIFF_W-1:0] seedRaw, seedVal, diffEff;
  logic [DIFF_W-1:0] laneVal [NUM_LANES];
  logic [WORD_W-1:0] laneHot [NUM_LANES];

  always_comb begin
    seedRaw = trellisMode ? (groupNum + DIFF_W'(1)) : groupNum;
    seedVal = (seedRaw == '0) ? DIFF_W'(1) : seedRaw;
    if (ctl.load)      diffEff = seedVal;
    else if (ctl.step) diffEff = galoisStep(diffState);
    else               diffEff = diffState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) diffState <= DIFF_W'(1);
    else       diffState <= diffEff;
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    localparam int SHIFT = j * SPACING;
    logic [DIFF_W-1:0] shifted;
    always_comb begin
      shifted = diffEff;
      for (int i = 0; i < SHIFT; i++) shifted = galoisStep(shifted);
    end
    if (j == 0) begin : g_gated
      assign laneVal[j] = ctl.firstBeat ? '0 : shifted;
    end else begin : g_plain
      assign laneVal[j] = shifted;
    end
    assign laneHot[j] = WORD_W'(1) << (partitionNum ^ laneVal[j]);
  end

  always_comb begin
    colMask = '0;
    for (int j = 0; j < NUM_LANES; j++) colMask = colMask | laneHot[j];
    if (colDisable) colMask = '1;
  end

  p_disable_ones_r1: assert property (@(posedge clk) disable iff (!rstN)
    colDisable |-> (colMask == '1));
  p_nonzero_state_r4: assert property (@(posedge clk) disable iff (!rstN)
    diffState != '0);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.step) |=> $stable(diffState));
  p_lane0_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.firstBeat && !colDisable) |-> colMask[partitionNum]);
  p_popcount_r8: assert property (@(posedge clk) disable iff (!rstN)
    !colDisable |-> ($countones(colMask) >= 1 && $countones(colMask) <= NUM_LANES));
endmodule

// File: rtl/rom_col_selector.sv
module rom_col_selector
  import rcs_pkg::*;
#(
  parameter int                DIFF_W    = 3,
  parameter logic [DIFF_W-1:0] TAPS      = 3'b011,
  parameter int                NUM_LANES = 2,
  parameter int                ADDR_W    = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   runStart,
  input  logic                   trellisMode,
  input  logic                   colDisable,
  input  logic [DIFF_W-1:0]      groupNum,
  input  logic [DIFF_W-1:0]      partitionNum,
  input  logic [ADDR_W-1:0]      wordAddr,
  output logic [(1<<DIFF_W)-1:0] colMask
);
  rcsCtl_t ctl;

  rcs_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .runStart(runStart), .wordAddr(wordAddr), .ctl(ctl)
  );

  rcs_datapath #(.DIFF_W(DIFF_W), .TAPS(TAPS), .NUM_LANES(NUM_LANES)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .trellisMode(trellisMode),
    .colDisable(colDisable), .groupNum(groupNum), .partitionNum(partitionNum),
    .colMask(colMask)
  );
endmodule

// File: tb/rom_col_selector_tb_top.sv
module rom_col_selector_tb_top;
  localparam int DIFF_W = 3;
  localparam int ADDR_W = 4;
  localparam int LANES  = 2;
  localparam int WORD_W = 1 << DIFF_W;
  localparam int SPACING = (WORD_W - 1) / LANES;
  localparam logic [DIFF_W-1:0] TAPS = 3'b011;

  logic clk = 0, rstN = 0;
  logic runStart = 0, trellisMode = 0, colDisable = 0;
  logic [DIFF_W-1:0] groupNum = '0, partitionNum = '0;
  logic [ADDR_W-1:0] wordAddr = '0;
  logic [WORD_W-1:0] colMask;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DIFF_W-1:0] mState;
  logic [ADDR_W-1:0] mPrev;

  always #4 clk = ~clk;

  rom_col_selector #(.DIFF_W(DIFF_W), .TAPS(TAPS), .NUM_LANES(LANES), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .runStart(runStart), .trellisMode(trellisMode),
    .colDisable(colDisable), .groupNum(groupNum), .partitionNum(partitionNum),
    .wordAddr(wordAddr), .colMask(colMask)
  );

  function automatic logic [DIFF_W-1:0] mStep(input logic [DIFF_W-1:0] s);
    return {s[DIFF_W-2:0], 1'b0} ^ (s[DIFF_W-1] ? TAPS : '0);
  endfunction

  function automatic logic [DIFF_W-1:0] effState();
    logic [DIFF_W-1:0] sd;
    if (runStart) begin
      sd = trellisMode ? groupNum + 1'b1 : groupNum;   // R2 R3
      if (sd == 0) sd = 1;                             // R4
      return sd;
    end
    return (wordAddr != mPrev) ? mStep(mState) : mState; // R5
  endfunction

  function automatic logic [WORD_W-1:0] expMask();
    logic [WORD_W-1:0] m = '0;
    logic [DIFF_W-1:0] e = effState();
    if (colDisable) return '1;                         // R1
    for (int j = 0; j < LANES; j++) begin
      logic [DIFF_W-1:0] v = e;
      for (int i = 0; i < j * SPACING; i++) v = mStep(v); // R6
      if (j == 0 && wordAddr == 0) v = '0;              // R7
      m[partitionNum ^ v] = 1'b1;                       // R8
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [WORD_W-1:0] exp);
    checks++;
    if (colMask !== exp) begin
      fails++;
      $display("FAIL %s: colMask=%h expected=%h", req, colMask, exp);
    end
  endtask

  // drive one cycle, check mid-cycle, then advance the model at the edge
  task automatic cyc(input bit rs, input bit tr, input bit dis,
                     input logic [DIFF_W-1:0] g, input logic [DIFF_W-1:0] p,
                     input logic [ADDR_W-1:0] a, input string req, input bit useLit,
                     input logic [WORD_W-1:0] lit);
    logic [DIFF_W-1:0] nxt;
    @(negedge clk);
    runStart = rs; trellisMode = tr; colDisable = dis;
    groupNum = g; partitionNum = p; wordAddr = a;
    #1;
    check(req, useLit ? lit : expMask());
    nxt = effState();
    @(posedge clk);
    mState = nxt; mPrev = a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int unused;
    logic [ADDR_W-1:0] a;
    unused = $urandom(32'd4242);
    mState = 1; mPrev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R9: reset state, diffractor 1 -> lanes 0 (gated) and 3
    cyc(0, 0, 0, 0, 0, 0, "R9", 1, 8'h09);
    // R2/R6: group 3, partition 2 -> known masks
    cyc(1, 0, 0, 3, 2, 0, "R2", 1, 8'h84);
    cyc(0, 0, 0, 3, 2, 1, "R6", 1, 8'h18);
    cyc(0, 0, 0, 3, 2, 1, "R5", 0, '0);   // hold
    cyc(0, 0, 0, 3, 2, 9, "R5", 0, '0);   // jump still one step
    cyc(0, 0, 1, 5, 6, 3, "R1", 1, 8'hFF);
    cyc(1, 1, 0, 7, 1, 0, "R4", 0, '0);   // 7+1 wraps to 0 -> 1
    cyc(1, 1, 0, 4, 0, 2, "R3", 0, '0);
    cyc(1, 0, 0, 0, 5, 0, "R4", 0, '0);
    cyc(0, 0, 0, 0, 5, 0, "R7", 0, '0);
    cyc(0, 0, 0, 0, 5, 1, "R8", 0, '0);
    a = 1;
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      if (r < 70) a = a + 1'b1;
      else if (r >= 85) a = ADDR_W'($urandom);
      cyc($urandom_range(0, 99) < 3, 1'($urandom), $urandom_range(0, 9) == 0,
          DIFF_W'($urandom), DIFF_W'($urandom), a, "R8 random", 0, '0);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule